// File: doc/BRIEF.md
# Atomic Word Reservation Unit

This block sits on the memory side of a shared word store and serves single-word atomic primitives next to plain reads and writes. A linked load returns the stored word and a signature that the unit allocates for the new reservation. A later store-conditional brings back that signature with its new data. It succeeds only while a reservation with the same address and signature is still held.

A compare-and-swap carries an expected value and a replacement. It writes only when the stored word equals the expected value. Both conditional operations answer with a one-bit success flag. Any successful write to a word cancels every reservation held on that word.

Each command is presented in one cycle with its opcode, word address and two 32-bit operands. The response appears one cycle later as one or two 32-bit words. The unit holds a small parameterised table of reservations and a parameterised array of words.

Top module: `atom_resv_unit`

## Requirements
- R1: After reset every word reads as zero, the table holds no reservation (a store-conditional fails), and `rspValid` and `rspTwo` are low.
- R2: A read (opcode 0, and the unused codes 5 to 7) returns the addressed word in `rspWord0` with `rspTwo` low.
- R3: A write (opcode 1) stores `cmdOpA` at the address and answers with `rspWord0` equal to zero.
- R4: A linked load (opcode 2) answers with two words: `rspWord0` holds the stored data, `rspWord1` holds the signature, and `rspTwo` is high. No other opcode raises `rspTwo`.
- R5: The first linked load after reset receives signature 0. Each later linked load receives the previous signature plus one.
- R6: A store-conditional (opcode 3, new data in `cmdOpA`, signature in `cmdOpB`) whose address and signature match a held reservation writes the data and answers 1.
- R7: A store-conditional with no matching reservation, whether the signature or the address differs, answers 0 and leaves the word unchanged.
- R8: A successful write by store-conditional, compare-and-swap or plain write cancels all reservations on that address. Reservations on other addresses remain.
- R9: A compare-and-swap (opcode 4, expected value in `cmdOpA`, replacement in `cmdOpB`) whose expected value equals the stored word writes the replacement and answers 1.
- R10: A compare-and-swap whose expected value differs answers 0 and leaves the word unchanged.
- R11: The table holds `ENTRIES` reservations. A linked load uses a free slot when one exists. When the table is full, the new reservation replaces the oldest one.
- R12: A failed store-conditional or compare-and-swap cancels no reservation.
- R13: Every accepted command yields exactly one response cycle, with `rspValid` high in the cycle after `cmdValid`. An idle cycle yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Opcode: 0 read, 1 write, 2 linked load, 3 store-conditional, 4 compare-and-swap |
| cmdAddr | input | $clog2(WORDS) | Word address |
| cmdOpA | input | 32 | Write data, store-conditional data, or expected value |
| cmdOpB | input | 32 | Signature for store-conditional, or replacement for compare-and-swap |
| rspValid | output | 1 | Response present |
| rspTwo | output | 1 | Response carries two words (linked load) |
| rspWord0 | output | 32 | First response word: data, flag or zero |
| rspWord1 | output | 32 | Second response word: signature |

## Verification
Store-conditionals are tried four ways: with the right pair, with a wrong signature on a reserved word, with a valid signature that belongs to another word, and after the reservation was consumed. Only the right pair must succeed.

Cancellation is driven separately by a plain write, by a compare-and-swap and by failed conditionals. This separates a write that cancels from a failed operation that must not. Compare-and-swap is run with a matching and a mismatching expected value.

The table is filled to capacity and overflowed. A slot is then freed, so the next linked load shows whether the victim choice prefers a free slot over the oldest entry.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_LL    = 3'd2,
    OP_SC    = 3'd3,
    OP_CAS   = 3'd4
  } atomOp_e;

  typedef enum logic [1:0] {
    RSP_DATA = 2'd0,
    RSP_LINK = 2'd1,
    RSP_FLAG = 2'd2,
    RSP_ACK  = 2'd3
  } rspKind_e;

  typedef struct packed {
    logic     rspLoad;
    logic     memWrite;
    logic     takeOpB;
    logic     resvAlloc;
    logic     resvKill;
    logic     flag;
    rspKind_e rspKind;
  } ctrlStrobe_t;
endpackage

// File: rtl/atom_ctrl.sv
module atom_ctrl
  import atom_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic        scHit,
  input  logic        casEqual,
  output ctrlStrobe_t strobe,
  output logic        rspValid
);
  atomOp_e opCode;
  assign opCode = atomOp_e'(cmdOp);

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      strobe.rspLoad = 1'b1;
      unique case (opCode)
        OP_WRITE: begin
          strobe.memWrite = 1'b1;
          strobe.resvKill = 1'b1;
          strobe.rspKind  = RSP_ACK;
        end
        OP_LL: begin
          strobe.resvAlloc = 1'b1;
          strobe.rspKind   = RSP_LINK;
        end
        OP_SC: begin
          strobe.flag     = scHit;
          strobe.memWrite = scHit;
          strobe.resvKill = scHit;
          strobe.rspKind  = RSP_FLAG;
        end
        OP_CAS: begin
          strobe.flag     = casEqual;
          strobe.memWrite = casEqual;
          strobe.takeOpB  = 1'b1;
          strobe.resvKill = casEqual;
          strobe.rspKind  = RSP_FLAG;
        end
        default: strobe.rspKind = RSP_DATA;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= cmdValid;
  end
endmodule

// File: rtl/atom_datapath.sv
module atom_datapath
  import atom_pkg::*;
#(
  parameter int WORDS   = 16,
  parameter int ENTRIES = 8,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdOpA,
  input  logic [DATA_W-1:0] cmdOpB,
  output logic              scHit,
  output logic              casEqual,
  output logic [DATA_W-1:0] rspWord0,
  output logic [DATA_W-1:0] rspWord1,
  output logic              rspTwo
);
  logic [DATA_W-1:0] memArr [WORDS];
  logic              entValid [ENTRIES];
  logic [ADDR_W-1:0] entAddr  [ENTRIES];
  logic [DATA_W-1:0] entSig   [ENTRIES];
  logic [DATA_W-1:0] sigCtr;
  logic [DATA_W-1:0] curWord;
  logic [IDX_W-1:0]  victim;
  logic [ENTRIES-1:0] addrMatch;
  logic [ENTRIES-1:0] pairMatch;

  assign curWord  = memArr[cmdAddr];
  assign casEqual = (curWord == cmdOpA);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gMatch
      assign addrMatch[g] = entValid[g] && (entAddr[g] == cmdAddr);
      assign pairMatch[g] = addrMatch[g] && (entSig[g] == cmdOpB);
    end
  endgenerate

  assign scHit = |pairMatch;

  // Victim: lowest free slot, else the entry with the greatest age.
  always_comb begin
    logic              foundFree;
    logic [DATA_W-1:0] bestAge;
    logic [DATA_W-1:0] thisAge;
    foundFree = 1'b0;
    victim    = '0;
    bestAge   = '0;
    thisAge   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!entValid[i] && !foundFree) begin
        foundFree = 1'b1;
        victim    = IDX_W'(i);
      end
    end
    if (!foundFree) begin
      bestAge = sigCtr - entSig[0];
      victim  = '0;
      for (int i = 1; i < ENTRIES; i++) begin
        thisAge = sigCtr - entSig[i];
        if (thisAge > bestAge) begin
          bestAge = thisAge;
          victim  = IDX_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) memArr[i] <= '0;
    end else if (strobe.memWrite) begin
      memArr[cmdAddr] <= strobe.takeOpB ? cmdOpB : cmdOpA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sigCtr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entValid[i] <= 1'b0;
        entAddr[i]  <= '0;
        entSig[i]   <= '0;
      end
    end else begin
      if (strobe.resvKill) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (addrMatch[i]) entValid[i] <= 1'b0;
        end
      end
      if (strobe.resvAlloc) begin
        entValid[victim] <= 1'b1;
        entAddr[victim]  <= cmdAddr;
        entSig[victim]   <= sigCtr;
        sigCtr           <= sigCtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspWord0 <= '0;
      rspWord1 <= '0;
      rspTwo   <= 1'b0;
    end else begin
      rspTwo <= 1'b0;
      if (strobe.rspLoad) begin
        unique case (strobe.rspKind)
          RSP_LINK: begin
            rspWord0 <= curWord;
            rspWord1 <= sigCtr;
            rspTwo   <= 1'b1;
          end
          RSP_FLAG: begin
            rspWord0 <= {{(DATA_W-1){1'b0}}, strobe.flag};
            rspWord1 <= '0;
          end
          RSP_ACK: begin
            rspWord0 <= '0;
            rspWord1 <= '0;
          end
          default: begin
            rspWord0 <= curWord;
            rspWord1 <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/atom_resv_unit.sv
module atom_resv_unit
  import atom_pkg::*;
#(
  parameter int WORDS   = 16,
  parameter int ENTRIES = 8,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdOpA,
  input  logic [31:0]       cmdOpB,
  output logic              rspValid,
  output logic              rspTwo,
  output logic [31:0]       rspWord0,
  output logic [31:0]       rspWord1
);
  ctrlStrobe_t strobe;
  logic        scHit;
  logic        casEqual;

  atom_ctrl ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .scHit(scHit), .casEqual(casEqual), .strobe(strobe), .rspValid(rspValid)
  );

  atom_datapath #(.WORDS(WORDS), .ENTRIES(ENTRIES)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr),
    .cmdOpA(cmdOpA), .cmdOpB(cmdOpB), .scHit(scHit), .casEqual(casEqual),
    .rspWord0(rspWord0), .rspWord1(rspWord1), .rspTwo(rspTwo)
  );
endmodule

// File: rtl/atom_resv_checker.sv
module atom_resv_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [2:0]  cmdOp,
  input logic        rspValid,
  input logic        rspTwo,
  input logic [31:0] rspWord0,
  input logic [31:0] rspWord1
);
  logic        primed;
  logic        sawLink;
  logic [31:0] nextSig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed  <= 1'b0;
      sawLink <= 1'b0;
      nextSig <= '0;
    end else begin
      primed <= 1'b1;
      if (rspValid && rspTwo) begin
        sawLink <= 1'b1;
        nextSig <= rspWord1 + 32'd1;
      end
    end
  end

  // R13
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> rspValid);

  // R13
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !rspValid);

  // R4
  link_two_flit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && rspValid) |-> (rspTwo == ($past(cmdOp) == 3'd2)));

  // R4
  two_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspTwo |-> rspValid);

  // R5
  sig_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspTwo && sawLink) |-> (rspWord1 == nextSig));

  // R6 R7 R9 R10
  flag_bool_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && rspValid && ($past(cmdOp) == 3'd3 || $past(cmdOp) == 3'd4))
      |-> (rspWord0[31:1] == 31'd0));

  // R3
  write_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && rspValid && $past(cmdOp) == 3'd1) |-> (rspWord0 == 32'd0));
endmodule

bind atom_resv_unit atom_resv_checker resvChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .rspValid(rspValid), .rspTwo(rspTwo), .rspWord0(rspWord0), .rspWord1(rspWord1)
);

// File: tb/atom_resv_unit_test.sv
module atom_resv_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [3:0]  cmdAddr = 4'd0;
  logic [31:0] cmdOpA = 32'd0;
  logic [31:0] cmdOpB = 32'd0;
  logic        rspValid;
  logic        rspTwo;
  logic [31:0] rspWord0;
  logic [31:0] rspWord1;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  atom_resv_unit #(.WORDS(16), .ENTRIES(8)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdOpA(cmdOpA), .cmdOpB(cmdOpB),
    .rspValid(rspValid), .rspTwo(rspTwo), .rspWord0(rspWord0), .rspWord1(rspWord1)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one command and sample its response one cycle later.
  task automatic issue(input logic [2:0] op, input logic [3:0] a,
                       input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdOpA = x; cmdOpB = y;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R13 valid", {31'd0, rspValid}, 32'd1);
  endtask

  task automatic expectRead(string req, logic [3:0] a, logic [31:0] exp);
    issue(3'd0, a, 32'd0, 32'd0);
    check(req, rspWord0, exp);
    check("R2 one flit", {31'd0, rspTwo}, 32'd0);
  endtask

  task automatic expectLink(logic [3:0] a, logic [31:0] data, logic [31:0] sig);
    issue(3'd2, a, 32'd0, 32'd0);
    check("R4 data", rspWord0, data);
    check("R5 sig", rspWord1, sig);
    check("R4 two", {31'd0, rspTwo}, 32'd1);
  endtask

  task automatic expectSc(string req, logic [3:0] a, logic [31:0] d,
                          logic [31:0] sig, logic [31:0] exp);
    issue(3'd3, a, d, sig);
    check(req, rspWord0, exp);
  endtask

  task automatic expectCas(string req, logic [3:0] a, logic [31:0] o,
                           logic [31:0] n, logic [31:0] exp);
    issue(3'd4, a, o, n);
    check(req, rspWord0, exp);
  endtask

  task automatic testReset();
    check("R1 rspValid", {31'd0, rspValid}, 32'd0);
    check("R1 rspTwo", {31'd0, rspTwo}, 32'd0);
    expectRead("R1 zero word", 4'd3, 32'd0);
    expectSc("R1 empty table", 4'd3, 32'h55, 32'd0, 32'd0);
    @(negedge clk);
    check("R13 idle", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic testReadWrite();
    issue(3'd1, 4'd5, 32'h0000A5A5, 32'd0);
    check("R3 ack", rspWord0, 32'd0);
    expectRead("R3 stored", 4'd5, 32'h0000A5A5);
    issue(3'd6, 4'd5, 32'd0, 32'd0);
    check("R2 unused code reads", rspWord0, 32'h0000A5A5);
  endtask

  task automatic testStoreCond();
    expectLink(4'd5, 32'h0000A5A5, 32'd0);
    expectLink(4'd6, 32'd0, 32'd1);
    expectSc("R7 wrong sig", 4'd5, 32'h1111, 32'd7, 32'd0);
    expectSc("R7 other addr sig", 4'd5, 32'h1111, 32'd1, 32'd0);
    expectRead("R7 unchanged", 4'd5, 32'h0000A5A5);
    expectSc("R6 success", 4'd5, 32'h1111, 32'd0, 32'd1);
    expectRead("R6 written", 4'd5, 32'h1111);
    expectSc("R8 consumed", 4'd5, 32'h2222, 32'd0, 32'd0);
    expectSc("R8 other addr kept", 4'd6, 32'h66, 32'd1, 32'd1);
  endtask

  task automatic testPlainWriteKill();
    expectLink(4'd7, 32'd0, 32'd2);
    issue(3'd1, 4'd7, 32'h77, 32'd0);
    expectSc("R8 plain write cancels", 4'd7, 32'h88, 32'd2, 32'd0);
    expectRead("R8 word kept", 4'd7, 32'h77);
  endtask

  task automatic testCas();
    issue(3'd1, 4'd8, 32'h10, 32'd0);
    expectCas("R10 mismatch", 4'd8, 32'h11, 32'h20, 32'd0);
    expectRead("R10 unchanged", 4'd8, 32'h10);
    expectCas("R9 match", 4'd8, 32'h10, 32'h20, 32'd1);
    expectRead("R9 written", 4'd8, 32'h20);
    expectLink(4'd8, 32'h20, 32'd3);
    expectCas("R9 match again", 4'd8, 32'h20, 32'h30, 32'd1);
    expectSc("R8 cas cancels", 4'd8, 32'h40, 32'd3, 32'd0);
    expectRead("R8 cas value", 4'd8, 32'h30);
  endtask

  task automatic testFailKeeps();
    expectLink(4'd9, 32'd0, 32'd4);
    expectCas("R12 cas fails", 4'd9, 32'hDEAD, 32'h1, 32'd0);
    expectSc("R12 sc fails", 4'd9, 32'h1, 32'd99, 32'd0);
    expectSc("R12 reservation kept", 4'd9, 32'h99, 32'd4, 32'd1);
  endtask

  task automatic testCapacity();
    // eight links fill the table: addresses 10..15,0,1 with signatures 5..12
    for (int k = 0; k < 8; k++) begin
      logic [3:0] a;
      a = 4'(10 + k);
      issue(3'd2, a, 32'd0, 32'd0);
      check("R5 fill sig", rspWord1, 32'(5 + k));
    end
    issue(3'd2, 4'd2, 32'd0, 32'd0);
    check("R11 overflow sig", rspWord1, 32'd13);
    expectSc("R11 oldest evicted", 4'd10, 32'h5, 32'd5, 32'd0);
    expectSc("R11 second kept", 4'd11, 32'h6, 32'd6, 32'd1);
    issue(3'd2, 4'd3, 32'd0, 32'd0);
    check("R11 free slot sig", rspWord1, 32'd14);
    expectSc("R11 free slot used", 4'd12, 32'h7, 32'd7, 32'd1);
    expectSc("R11 newest kept", 4'd2, 32'h8, 32'd13, 32'd1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadWrite();
    testStoreCond();
    testPlainWriteKill();
    testCas();
    testFailKeeps();
    testCapacity();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule